// File: doc/BRIEF.md
# Micro-tick interval timer

This block measures a programmed number of periods of a dedicated timer clock and raises an interrupt when that count runs out. Software reaches it through a simple register port in the bus clock domain. The counter itself runs in a separate timer clock domain, which is usually slower and may be unrelated in phase. One register sets the interval length and chooses between a single delay and a free-running periodic tick. The other register reports a pending interrupt and whether the counter is running. Writing any value to that second register clears the pending interrupt.

A control write is held in the bus domain and sent across to the timer domain by a toggle handshake. The bus-side sequencer has two states. `HS_IDLE` waits for a pending write and launches it with the `launch` transition, which goes to `HS_WAIT`. `HS_WAIT` holds the transfer word stable until the acknowledge comes back (`ack` transition to `HS_IDLE`). The timer-side sequencer also has two states. `T_IDLE` means stopped. `T_COUNT` counts down. A delivered write gives the `load` transition into `T_COUNT`, or into `T_IDLE` when the value is zero. Expiry in single mode gives the `expire` transition back to `T_IDLE`. Expiry in periodic mode gives the `reload` transition, which stays in `T_COUNT`. The expiry events and the running level come back to the bus domain through two-flop synchronizers.

Top module: `tick_timer`

## Requirements
- R1: After reset, both the control register (offset 0x0) and the status register (offset 0x4) read zero and `irq` is low.
- R2: A read at offset 0x0 returns the last value written there: bits 30:0 are the delay value D and bit 31 is the periodic-mode bit.
- R3: After a control write with D > 0, the first expiry occurs D+1 timer-clock periods after the value reaches the timer domain.
- R4: With bit 31 clear, exactly one expiry occurs, after which the running flag returns to 0 and reads as status 0x1 until cleared.
- R5: With bit 31 set, expiries repeat with a period of exactly D+1 timer-clock periods, with no cycle lost between intervals.
- R6: Writing D = 0 stops the counter: the running flag goes to 0 and no further expiry occurs.
- R7: Any control write abandons the interval in progress and starts a new one from the written value.
- R8: A write of any data to offset 0x4 clears the pending flag. If an expiry arrives in the same bus cycle, the expiry wins and the flag stays set.
- R9: The status register holds the pending flag in bit 0 and the running flag in bit 1, and reads bits 31:2 as zero.
- R10: `irq` is a bus-domain level equal to status bit 0 at all times.
- R11: Control writes that follow each other before the previous one has crossed are not lost: the last written value takes effect.
- R12: D = 1 gives the shortest interval of two timer-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| tmr_clk | input | 1 | Counting clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| reg_we | input | 1 | Write strobe, one bus cycle per write |
| reg_addr | input | ADDR_W (4) | Byte offset: 0x0 control, 0x4 status |
| reg_wdata | input | DLY_W+1 (32) | Write data |
| reg_rdata | output | DLY_W+1 (32) | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt-pending level |

## Verification
A counter that loads or decrements wrongly shows up at `irq` as a period between repeated interrupts that differs from D+1 timer clocks. This is visible from the second expiry onward, within a few timer periods of the fault. A handshake that drops a pending write leaves the old interval running, so the interrupt arrives thousands of cycles late or is missing altogether. A pending flag that is wrongly cleared hides an expiry that arrives together with a status write, so `irq` stays low for the whole burst of writes. A timer sequencer stuck in the wrong state shows in status bit 1 on the next read, and in interrupts that continue after a stop.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int CTRL_OFS = 'h0;
    localparam int STAT_OFS = 'h4;

    typedef enum logic {
        HS_IDLE,
        HS_WAIT
    } hs_state_e;

    typedef enum logic {
        T_IDLE,
        T_COUNT
    } tmr_state_e;

endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stg
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tick_bus_side.sv
module tick_bus_side
    import tick_pkg::*;
#(
    parameter int DLY_W  = 31,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DLY_W:0]    wdata,
    input  logic              ack_s,
    input  logic              exp_s,
    input  logic              act_s,
    output logic [DLY_W:0]    rdata,
    output logic              irq,
    output logic              req_tgl,
    output logic [DLY_W:0]    xfer,
    output logic              exp_pulse,
    output logic              stat_wr
);

    hs_state_e      st_q, st_d;
    logic [DLY_W:0] ctrl_q;
    logic [DLY_W:0] xfer_q;
    logic           dirty_q;
    logic           req_q;
    logic           exp_prev_q;
    logic           irq_q;
    logic           ctrl_wr;
    logic           launch;

    assign ctrl_wr   = we && (addr == ADDR_W'(CTRL_OFS));
    assign stat_wr   = we && (addr == ADDR_W'(STAT_OFS));
    assign launch    = (st_q == HS_IDLE) && dirty_q;
    assign exp_pulse = exp_s ^ exp_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE: if (dirty_q)        st_d = HS_WAIT;
            HS_WAIT: if (ack_s == req_q) st_d = HS_IDLE;
        endcase
    end

    // registered outputs and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            xfer_q     <= '0;
            dirty_q    <= 1'b0;
            req_q      <= 1'b0;
            exp_prev_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata;
            dirty_q <= ctrl_wr | (dirty_q & ~launch);
            if (launch) begin
                xfer_q <= ctrl_q;
                req_q  <= ~req_q;
            end
            exp_prev_q <= exp_s;
            irq_q      <= exp_pulse | (irq_q & ~stat_wr);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS))      rdata      = ctrl_q;
        else if (addr == ADDR_W'(STAT_OFS)) rdata[1:0] = {act_s, irq_q};
    end

    assign irq     = irq_q;
    assign req_tgl = req_q;
    assign xfer    = xfer_q;

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int DLY_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic [DLY_W:0]   xfer,
    output logic             ack,
    output logic             exp_tgl,
    output logic             active,
    output logic             load,
    output logic [DLY_W-1:0] cnt
);

    tmr_state_e       st_q, st_d;
    logic             req_prev_q;
    logic             rep_q;
    logic             exp_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] new_dly;

    assign new_dly = xfer[DLY_W-1:0];
    assign load    = req_s ^ req_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    // next state: load, expire, reload
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = (new_dly != '0) ? T_COUNT : T_IDLE;
        end else begin
            unique case (st_q)
                T_IDLE:  st_d = T_IDLE;
                T_COUNT: if (cnt_q == '0 && !rep_q) st_d = T_IDLE;
            endcase
        end
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
            rep_q      <= 1'b0;
            exp_q      <= 1'b0;
            dly_q      <= '0;
            cnt_q      <= '0;
        end else begin
            req_prev_q <= req_s;
            if (load) begin
                rep_q <= xfer[DLY_W];
                dly_q <= new_dly;
                cnt_q <= new_dly;
            end else if (st_q == T_COUNT) begin
                if (cnt_q == '0) begin
                    exp_q <= ~exp_q;
                    cnt_q <= dly_q;
                end else begin
                    cnt_q <= cnt_q - DLY_W'(1);
                end
            end
        end
    end

    assign ack     = req_prev_q;
    assign exp_tgl = exp_q;
    assign active  = (st_q == T_COUNT);
    assign cnt     = cnt_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int DLY_W       = 31,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DLY_W:0]    reg_wdata,
    output logic [DLY_W:0]    reg_rdata,
    output logic              irq
);

    logic             req_tgl, req_t;
    logic [DLY_W:0]   xfer_data;
    logic             ack_t, exp_tgl, t_active, t_load;
    logic [DLY_W-1:0] t_cnt;
    logic             ack_b, exp_b, act_b;
    logic             exp_pulse, stat_wr;

    tick_bus_side #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_bus (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ack_s    (ack_b),
        .exp_s    (exp_b),
        .act_s    (act_b),
        .rdata    (reg_rdata),
        .irq      (irq),
        .req_tgl  (req_tgl),
        .xfer     (xfer_data),
        .exp_pulse(exp_pulse),
        .stat_wr  (stat_wr)
    );

    tick_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (tmr_clk),
        .rst_n(tmr_rst_n),
        .d    (req_tgl),
        .q    (req_t)
    );

    tick_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk    (tmr_clk),
        .rst_n  (tmr_rst_n),
        .req_s  (req_t),
        .xfer   (xfer_data),
        .ack    (ack_t),
        .exp_tgl(exp_tgl),
        .active (t_active),
        .load   (t_load),
        .cnt    (t_cnt)
    );

    tick_sync #(.W(3), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk  (bus_clk),
        .rst_n(bus_rst_n),
        .d    ({ack_t, exp_tgl, t_active}),
        .q    ({ack_b, exp_b, act_b})
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_pkg::*;
#(
    parameter int DLY_W  = 31,
    parameter int ADDR_W = 4
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              tmr_clk,
    input logic              tmr_rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DLY_W:0]    reg_rdata,
    input logic              irq,
    input logic              exp_pulse,
    input logic              stat_wr,
    input logic              req_tgl,
    input logic              ack_b,
    input logic [DLY_W:0]    xfer_data,
    input logic              t_active,
    input logic              t_load,
    input logic [DLY_W-1:0]  t_cnt,
    input logic              exp_tgl
);

    // R8
    irq_set_wins_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        exp_pulse |=> irq);

    // R8
    irq_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (stat_wr && !exp_pulse) |=> !irq);

    // R9
    stat_rsvd_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (reg_addr == ADDR_W'(STAT_OFS)) |-> (reg_rdata[DLY_W:2] == '0));

    // R11
    xfer_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (req_tgl != ack_b) |=> $stable(xfer_data));

    // R3
    cnt_dec_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (t_active && !t_load && t_cnt != '0) |=> (t_cnt == $past(t_cnt) - DLY_W'(1)));

    // R5
    expire_tgl_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (t_active && !t_load && t_cnt == '0) |=> (exp_tgl != $past(exp_tgl)));

    // R6
    zero_stop_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (t_load && xfer_data[DLY_W-1:0] == '0) |=> !t_active);

endmodule

bind tick_timer tick_timer_chk #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_chk (
    .bus_clk  (bus_clk),
    .bus_rst_n(bus_rst_n),
    .tmr_clk  (tmr_clk),
    .tmr_rst_n(tmr_rst_n),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .exp_pulse(exp_pulse),
    .stat_wr  (stat_wr),
    .req_tgl  (req_tgl),
    .ack_b    (ack_b),
    .xfer_data(xfer_data),
    .t_active (t_active),
    .t_load   (t_load),
    .t_cnt    (t_cnt),
    .exp_tgl  (exp_tgl)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam int         TPER   = 20;

    logic        bus_clk   = 1'b0;
    logic        tmr_clk   = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        tmr_rst_n = 1'b0;
    logic        reg_we    = 1'b0;
    logic [3:0]  reg_addr  = A_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int     checks = 0;
    int     errors = 0;
    longint rise_q[$];
    logic   irq_prev = 1'b0;
    logic   done = 1'b0;

    tick_timer dut (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .tmr_clk  (tmr_clk),
        .tmr_rst_n(tmr_rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    always #2 bus_clk = ~bus_clk;
    initial begin
        #1;
        forever begin
            tmr_clk = ~tmr_clk;
            #10;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock model: interrupt edges and status view compared every bus cycle
    always @(negedge bus_clk) begin
        if (bus_rst_n) begin
            irq_prev <= irq;
            if (irq && !irq_prev) rise_q.push_back($time);
            if (!reg_we && reg_addr == A_STAT) begin
                chk(reg_rdata[0] === irq, "R10", longint'(reg_rdata[0]), longint'(irq));
                chk(reg_rdata[31:2] == '0, "R9", longint'(reg_rdata[31:2]), 0);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        #0.5;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        #0.5;
        reg_we = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        #0.5;
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = A_STAT;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic wait_rises(input int n, input int maxc);
        int c = 0;
        while (rise_q.size() < n && c < maxc) begin
            @(negedge bus_clk);
            c++;
        end
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        idle(60);
        wr(A_STAT, 32'h0);
        idle(4);
        rise_q.delete();
    endtask

    task automatic periodic(input int d, input string req);
        quiesce();
        wr(A_CTRL, 32'h8000_0000 | d);
        for (int i = 0; i < 5; i++) begin
            wait_rises(i + 1, 400);
            wr(A_STAT, 32'h0);
        end
        chk(rise_q.size() == 5, req, rise_q.size(), 5);
        for (int i = 1; i < rise_q.size(); i++)
            chk(rise_q[i] - rise_q[i-1] == longint'((d + 1) * TPER), req,
                rise_q[i] - rise_q[i-1], (d + 1) * TPER);
    endtask

    initial begin
        logic [31:0] v;
        longint tw;
        int hi;
        #25;
        bus_rst_n = 1'b1;
        tmr_rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTRL, v); chk(v == 32'h0, "R1", v, 0);
        rd(A_STAT, v); chk(v == 32'h0, "R1", v, 0);
        chk(irq == 1'b0, "R1", irq, 0);

        // R2, R3, R4 one-shot with D=5
        rise_q.delete();
        tw = $time;
        wr(A_CTRL, 32'h0000_0005);
        rd(A_CTRL, v); chk(v == 32'h5, "R2", v, 5);
        wait_rises(1, 400);
        chk(rise_q.size() == 1, "R3", rise_q.size(), 1);
        if (rise_q.size() > 0) begin
            chk(rise_q[0] - tw >= 6 * TPER, "R3", rise_q[0] - tw, 6 * TPER);
            chk(rise_q[0] - tw <= 6 * TPER + 120, "R3", rise_q[0] - tw, 6 * TPER + 120);
        end
        idle(20);
        rd(A_STAT, v); chk(v == 32'h1, "R4", v, 1);
        wr(A_STAT, 32'hDEAD_BEEF);
        idle(2);
        rd(A_STAT, v); chk(v == 32'h0, "R8", v, 0);
        chk(irq == 1'b0, "R8", irq, 0);
        idle(300);
        chk(rise_q.size() == 1, "R4", rise_q.size(), 1);

        // R12 shortest periodic interval, R5 longer periodic interval
        periodic(1, "R12");
        periodic(9, "R5");

        // R6 stop by zero
        wr(A_CTRL, 32'h8000_0000);
        idle(60);
        wr(A_STAT, 32'h0);
        idle(2);
        rise_q.delete();
        idle(400);
        chk(rise_q.size() == 0, "R6", rise_q.size(), 0);
        rd(A_STAT, v); chk(v == 32'h0, "R6", v, 0);
        rd(A_CTRL, v); chk(v == 32'h8000_0000, "R2", v, 32'h8000_0000);

        // R7 restart mid-interval
        quiesce();
        wr(A_CTRL, 32'd30);
        idle(75);
        rd(A_STAT, v); chk(v == 32'h2, "R9", v, 2);
        tw = $time;
        wr(A_CTRL, 32'd30);
        wait_rises(1, 600);
        chk(rise_q.size() == 1, "R7", rise_q.size(), 1);
        if (rise_q.size() > 0) begin
            chk(rise_q[0] - tw >= 31 * TPER, "R7", rise_q[0] - tw, 31 * TPER);
            chk(rise_q[0] - tw <= 31 * TPER + 120, "R7", rise_q[0] - tw, 31 * TPER + 120);
        end

        // R11 back-to-back control writes, last value wins
        quiesce();
        wr(A_CTRL, 32'd200);
        tw = $time;
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, v); chk(v == 32'd3, "R11", v, 3);
        wait_rises(1, 300);
        chk(rise_q.size() == 1, "R11", rise_q.size(), 1);
        if (rise_q.size() > 0)
            chk(rise_q[0] - tw <= 4 * TPER + 200, "R11", rise_q[0] - tw, 4 * TPER + 200);
        idle(100);
        rd(A_STAT, v); chk(v == 32'h1, "R11", v, 1);

        // R8 expiry wins over a clear in the same cycle
        quiesce();
        wr(A_CTRL, 32'h8000_0004);
        idle(10);
        @(negedge bus_clk);
        #0.5;
        reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h5A5A_A5A5;
        hi = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge bus_clk);
            if (irq) hi++;
        end
        #0.5;
        reg_we = 1'b0;
        chk(hi >= 2 && hi <= 4, "R8", hi, 3);
        quiesce();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule